// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a single-bit serial slave that owns one 16-bit configuration word standing in for a nonvolatile setting. A host lowers chip select, shifts in an 8-bit opcode and, depending on the opcode, either reads the word back, arms writing, writes a new word or clears an error flag. All serial inputs are oversampled by the system clock through a two-stage synchronizer. Edges of the serial clock are detected in the system clock domain, so the serial clock must run well below the system clock: each serial phase has to last at least four system clocks.

A write is only honoured when a write-enable latch has been armed by an earlier frame and the host raises chip select right after the sixteenth data bit. An accepted write starts a self-timed programming interval of `PROG_CYCLES` system clocks. During that interval a busy flag is raised. At its end the word is updated and the latch drops. A write that is refused sets a sticky error flag, and a dedicated opcode clears it.

The read data line is driven only while read data is being returned. The rest of the time its output enable stays low, so the pad can float.

Top module: `nvcfg_spi_slave`

## Requirements
- R1: After reset the word equals `CFG_RESET` (0xFFFF by default), and `busy`, `wel` and `err_flag` and `miso_oe` are all low.
- R2: A frame starts when `cs_n` falls. The first 8 bits sampled on rising `sck` form the opcode, MSB first. An opcode other than 0x06, 0xB5, 0xB1 or 0x50 makes every later bit of that frame irrelevant until `cs_n` rises.
- R3: Opcode 0x06 sets `wel` once its eighth bit is sampled, unless `busy` is high.
- R4: Opcode 0xB5 returns the word on `miso`, with each bit changing after a falling `sck`. The low byte comes first, then the high byte, and each byte is sent MSB first. Further clocks with `cs_n` low repeat the same 16-bit sequence.
- R5: `miso_oe` is low while the opcode is shifted and whenever `cs_n` is high. It is high during the data phase of a read.
- R6: Opcode 0xB1 takes 16 data bits, low byte first and MSB first within each byte. The write is accepted only if `wel` is set, `busy` is low, and `cs_n` rises after exactly 16 data bits.
- R7: A 0xB1 frame refused for a clear `wel` or for a data bit count other than 16 leaves the word unchanged and sets `err_flag`. A count refusal leaves `wel` unchanged.
- R8: An accepted write raises `busy` for exactly `PROG_CYCLES` clocks. When `busy` falls, the word takes the new value and `wel` clears. The word changes at no other time.
- R9: While `busy` is high, 0x06 and 0xB1 frames have no effect and do not set `err_flag`.
- R10: Opcode 0x50 clears `err_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output enable for the `miso` pad |
| cfg_value | output | DW | Current configuration word |
| busy | output | 1 | Programming interval in progress |
| wel | output | 1 | Write-enable latch |
| err_flag | output | 1 | Sticky refused-write flag |

## Verification
Some properties are checked on every clock:
- the output enable stays off during the opcode and after chip select has been high for two samples;
- at most one command pulse fires at a time;
- a commit happens only with the latch set and not busy;
- the word holds steady except on the cycle the busy flag falls, and the latch is clear at that point;
- the programming counter stays in range.

The bench scenarios cover the rest: the byte order and repetition of read data, the length of the busy interval, refusal of short and long writes, and the silent dropping of commands during busy. They also show that bits following an unknown opcode do nothing.

// File: rtl/cfgspi_pkg.sv
package cfgspi_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDCFG = 8'hB5;
  localparam logic [7:0] OP_WRCFG = 8'hB1;
  localparam logic [7:0] OP_CLRF  = 8'h50;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_READ,
    PH_WRITE,
    PH_SKIP
  } phase_t;

endpackage

// File: rtl/cfgspi_sync.sv
module cfgspi_sync #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         rst_sync_n
);

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [1:0]               rs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      for (int s = STAGES - 1; s > 0; s--) stg_q[s] <= stg_q[s-1];
      stg_q[0] <= d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end

  assign q          = stg_q[STAGES-1];
  assign rst_sync_n = rs_q[1];

endmodule

// File: rtl/cfgspi_frame.sv
module cfgspi_frame
  import cfgspi_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_s,
  input  logic          cs_s,
  input  logic          mosi_s,
  input  logic [DW-1:0] cfg_i,
  input  logic          busy_i,
  input  logic          wel_i,
  output logic          wren_o,
  output logic          clrf_o,
  output logic          commit_o,
  output logic          reject_o,
  output logic [DW-1:0] wdata_o,
  output logic          miso_o,
  output logic          oe_o
);

  localparam int CNTW = $clog2(DW + 2);
  localparam int POSW = $clog2(DW);
  localparam int NB   = DW / 8;

  phase_t          ph_q, ph_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [DW-1:0]   sh_q, sh_d;
  logic [POSW-1:0] pos_q, pos_d;
  logic            miso_q, miso_d;
  logic            oe_q, oe_d;
  logic            sck_p, cs_p;

  logic            sck_rise, sck_fall, cs_fall, cs_rise;
  logic [7:0]      opcode;
  logic [POSW-1:0] idx;

  assign sck_rise = sck_s & ~sck_p & ~cs_s;
  assign sck_fall = ~sck_s & sck_p & ~cs_s;
  assign cs_fall  = ~cs_s & cs_p;
  assign cs_rise  = cs_s & ~cs_p;
  assign opcode   = {sh_q[6:0], mosi_s};
  // byte index kept, bit within byte mirrored: low byte first, MSB first
  assign idx      = {pos_q[POSW-1:3], ~pos_q[2:0]};

  for (genvar b = 0; b < NB; b++) begin : g_reorder
    assign wdata_o[8*b +: 8] = sh_q[DW-1-8*b -: 8];
  end

  always_comb begin
    ph_d     = ph_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    pos_d    = pos_q;
    miso_d   = miso_q;
    oe_d     = oe_q;
    wren_o   = 1'b0;
    clrf_o   = 1'b0;
    commit_o = 1'b0;
    reject_o = 1'b0;
    if (cs_fall) begin
      ph_d  = PH_CMD;
      cnt_d = '0;
      oe_d  = 1'b0;
    end else if (cs_rise) begin
      ph_d = PH_IDLE;
      oe_d = 1'b0;
      if (ph_q == PH_WRITE && !busy_i) begin
        if (wel_i && cnt_q == CNTW'(DW)) commit_o = 1'b1;
        else                             reject_o = 1'b1;
      end
    end else if (sck_rise) begin
      unique case (ph_q)
        PH_CMD: begin
          sh_d  = {sh_q[DW-2:0], mosi_s};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNTW'(7)) begin
            cnt_d = '0;
            unique case (opcode)
              OP_WREN:  begin wren_o = 1'b1; ph_d = PH_SKIP; end
              OP_RDCFG: begin ph_d = PH_READ; pos_d = '0; end
              OP_WRCFG: ph_d = PH_WRITE;
              OP_CLRF:  begin clrf_o = 1'b1; ph_d = PH_SKIP; end
              default:  ph_d = PH_SKIP;
            endcase
          end
        end
        PH_WRITE: begin
          sh_d = {sh_q[DW-2:0], mosi_s};
          if (cnt_q != CNTW'(DW + 1)) cnt_d = cnt_q + 1'b1;
        end
        default: ;
      endcase
    end else if (sck_fall && ph_q == PH_READ) begin
      miso_d = cfg_i[idx];
      pos_d  = pos_q + 1'b1;
      oe_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      pos_q  <= '0;
      miso_q <= 1'b0;
      oe_q   <= 1'b0;
      sck_p  <= 1'b0;
      cs_p   <= 1'b1;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      pos_q  <= pos_d;
      miso_q <= miso_d;
      oe_q   <= oe_d;
      sck_p  <= sck_s;
      cs_p   <= cs_s;
    end
  end

  assign miso_o = miso_q;
  assign oe_o   = oe_q;

  assert_hiz_opcode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_CMD) |-> !oe_q);
  assert_hiz_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && cs_p) |-> !oe_q);
  assert_single_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wren_o, clrf_o, commit_o, reject_o}));

endmodule

// File: rtl/cfgspi_prog.sv
module cfgspi_prog #(
  parameter int          DW          = 16,
  parameter int          PROG_CYCLES = 64,
  parameter logic [15:0] CFG_RESET   = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wren_i,
  input  logic          clrf_i,
  input  logic          commit_i,
  input  logic          reject_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cfg_o,
  output logic          busy_o,
  output logic          wel_o,
  output logic          err_o
);

  localparam int BW = $clog2(PROG_CYCLES + 1);

  logic [DW-1:0] cfg_q, cfg_d, pend_q, pend_d;
  logic [BW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d, wel_q, wel_d, err_q, err_d;

  always_comb begin
    cfg_d  = cfg_q;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    wel_d  = wel_q;
    err_d  = err_q;
    if (!busy_q) begin
      if (wren_i) wel_d = 1'b1;
      if (commit_i) begin
        busy_d = 1'b1;
        cnt_d  = BW'(PROG_CYCLES - 1);
        pend_d = wdata_i;
      end
    end else if (cnt_q == '0) begin
      busy_d = 1'b0;
      cfg_d  = pend_q;
      wel_d  = 1'b0;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
    if (reject_i)    err_d = 1'b1;
    else if (clrf_i) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= DW'(CFG_RESET);
      pend_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      wel_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      wel_q  <= wel_d;
      err_q  <= err_d;
    end
  end

  assign cfg_o  = cfg_q;
  assign busy_o = busy_q;
  assign wel_o  = wel_q;
  assign err_o  = err_q;

  assert_commit_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |-> (wel_q && !busy_q));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= BW'(PROG_CYCLES - 1)));
  assert_word_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy_q) |-> $stable(cfg_q));
  assert_latch_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> !wel_q);
  assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> !$rose(wel_q));

endmodule

// File: rtl/nvcfg_spi_slave.sv
module nvcfg_spi_slave #(
  parameter int          DW          = 16,
  parameter int          PROG_CYCLES = 64,
  parameter logic [15:0] CFG_RESET   = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          cs_n,
  input  logic          mosi,
  output logic          miso,
  output logic          miso_oe,
  output logic [DW-1:0] cfg_value,
  output logic          busy,
  output logic          wel,
  output logic          err_flag
);

  logic [2:0]    pins_s;
  logic          rst_i_n;
  logic          wren, clrf, commit, reject;
  logic [DW-1:0] wdata;

  cfgspi_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .d          ({cs_n, sck, mosi}),
    .q          (pins_s),
    .rst_sync_n (rst_i_n)
  );

  cfgspi_frame #(.DW(DW)) u_frame (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .sck_s    (pins_s[1]),
    .cs_s     (pins_s[2]),
    .mosi_s   (pins_s[0]),
    .cfg_i    (cfg_value),
    .busy_i   (busy),
    .wel_i    (wel),
    .wren_o   (wren),
    .clrf_o   (clrf),
    .commit_o (commit),
    .reject_o (reject),
    .wdata_o  (wdata),
    .miso_o   (miso),
    .oe_o     (miso_oe)
  );

  cfgspi_prog #(.DW(DW), .PROG_CYCLES(PROG_CYCLES), .CFG_RESET(CFG_RESET)) u_prog (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .wren_i   (wren),
    .clrf_i   (clrf),
    .commit_i (commit),
    .reject_i (reject),
    .wdata_i  (wdata),
    .cfg_o    (cfg_value),
    .busy_o   (busy),
    .wel_o    (wel),
    .err_o    (err_flag)
  );

endmodule

// File: tb/nvcfg_spi_slave_bench.sv
module nvcfg_spi_slave_bench;

  localparam int PROG = 2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0;
  logic        cs_n = 1'b1;
  logic        mosi = 1'b0;
  logic        miso, miso_oe, busy, wel, err_flag;
  logic [15:0] cfg_value;

  int total = 0;
  int bad = 0;
  int run_len = 0;
  int last_len = 0;

  always #2.5 clk = ~clk;

  nvcfg_spi_slave #(.DW(16), .PROG_CYCLES(PROG), .CFG_RESET(16'hFFFF)) u_nvcfg_spi_slave (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .cfg_value(cfg_value),
    .busy(busy), .wel(wel), .err_flag(err_flag)
  );

  always @(negedge clk) begin
    if (busy) run_len <= run_len + 1;
    else begin
      if (run_len != 0) last_len <= run_len;
      run_len <= 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one frame: opcode then nd data bits taken MSB-first from dbits
  task automatic xfer(input logic [7:0] op, input int nd, input logic [31:0] dbits,
                      output logic [31:0] rx, output logic oe_cmd, output int oe_hits);
    rx = '0; oe_cmd = 1'b0; oe_hits = 0;
    @(negedge clk) cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 8 + nd; i++) begin
      sck  = 1'b0;
      mosi = (i < 8) ? op[7-i] : dbits[31-(i-8)];
      repeat (7) @(negedge clk);
      if (i < 8) oe_cmd = oe_cmd | miso_oe;
      else begin
        rx = {rx[30:0], miso};
        if (miso_oe) oe_hits++;
      end
      @(negedge clk) sck = 1'b1;
      repeat (8) @(negedge clk);
    end
    sck = 1'b0;
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 3 * PROG && busy; n++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 word", cfg_value, 32'hFFFF);
    chk("R1 busy", busy, 0);
    chk("R1 wel", wel, 0);
    chk("R1 err", err_flag, 0);
    chk("R1 oe", miso_oe, 0);
  endtask

  task automatic t_read_default();
    logic [31:0] rx; logic oc; int oh;
    xfer(8'hB5, 16, 32'h0, rx, oc, oh);
    chk("R4 default read", rx[15:0], 32'hFFFF);
    chk("R5 hiz opcode", oc, 0);
    chk("R5 driven data", oh, 16);
  endtask

  task automatic t_write_no_wel();
    logic [31:0] rx; logic oc; int oh;
    xfer(8'hB1, 16, {8'h34, 8'h12, 16'h0}, rx, oc, oh);
    chk("R7 err on clear latch", err_flag, 1);
    chk("R7 word kept", cfg_value, 32'hFFFF);
    chk("R7 no busy", busy, 0);
  endtask

  task automatic t_clear();
    logic [31:0] rx; logic oc; int oh;
    xfer(8'h50, 0, 32'h0, rx, oc, oh);
    chk("R10 err cleared", err_flag, 0);
  endtask

  task automatic t_write_ok();
    logic [31:0] rx; logic oc; int oh;
    xfer(8'h06, 0, 32'h0, rx, oc, oh);
    chk("R3 wel set", wel, 1);
    xfer(8'hB1, 16, {8'h5A, 8'hA5, 16'h0}, rx, oc, oh);
    chk("R8 busy raised", busy, 1);
    chk("R8 word held while busy", cfg_value, 32'hFFFF);
    wait_idle();
    @(negedge clk);
    chk("R8 busy length", last_len, PROG);
    chk("R6 word written", cfg_value, 32'hA55A);
    chk("R8 wel cleared", wel, 0);
    chk("R6 no error", err_flag, 0);
  endtask

  task automatic t_read_repeat();
    logic [31:0] rx; logic oc; int oh;
    xfer(8'hB5, 32, 32'h0, rx, oc, oh);
    chk("R4 order and repeat", rx, 32'h5AA55AA5);
    chk("R5 hiz opcode", oc, 0);
    chk("R5 driven data", oh, 32);
    chk("R5 released", miso_oe, 0);
  endtask

  task automatic t_framing();
    logic [31:0] rx; logic oc; int oh;
    xfer(8'h06, 0, 32'h0, rx, oc, oh);
    xfer(8'hB1, 15, {8'h11, 8'h22, 16'h0}, rx, oc, oh);
    chk("R7 short err", err_flag, 1);
    chk("R7 short word", cfg_value, 32'hA55A);
    chk("R7 short wel kept", wel, 1);
    chk("R7 short no busy", busy, 0);
    xfer(8'h50, 0, 32'h0, rx, oc, oh);
    xfer(8'hB1, 17, {8'h11, 8'h22, 16'h8000}, rx, oc, oh);
    chk("R7 long err", err_flag, 1);
    chk("R7 long word", cfg_value, 32'hA55A);
    chk("R7 long no busy", busy, 0);
    xfer(8'h50, 0, 32'h0, rx, oc, oh);
    chk("R10 err cleared again", err_flag, 0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] rx; logic oc; int oh;
    xfer(8'hB1, 16, {8'h34, 8'h12, 16'h0}, rx, oc, oh);
    chk("R6 accepted", busy, 1);
    xfer(8'h06, 0, 32'h0, rx, oc, oh);
    xfer(8'hB1, 16, {8'hEF, 8'hBE, 16'h0}, rx, oc, oh);
    chk("R9 still busy", busy, 1);
    chk("R9 no error", err_flag, 0);
    wait_idle();
    @(negedge clk);
    chk("R9 first write kept", cfg_value, 32'h1234);
    chk("R9 wren dropped", wel, 0);
  endtask

  task automatic t_unknown();
    logic [31:0] rx; logic oc; int oh;
    xfer(8'h9F, 16, {8'h06, 8'h06, 16'h0}, rx, oc, oh);
    chk("R2 no drive", oh + int'(oc), 0);
    chk("R2 wel untouched", wel, 0);
    chk("R2 word untouched", cfg_value, 32'h1234);
    chk("R2 err untouched", err_flag, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_read_default();
    t_write_no_wel();
    t_clear();
    t_write_ok();
    t_read_repeat();
    t_framing();
    t_busy_ignore();
    t_unknown();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule